// File: doc/BRIEF.md
# Clock Source Switching Controller

This block chooses which of several oscillator sources drives the system clock and moves from one source to another without producing a runt pulse. It keeps a current-source field, a software-writable next-source field, a self-clearing switch-request bit, a software lock bit, a PLL-locked flag and a clock-fail flag. The analog oscillators and the PLL are outside the block. Each source reports a ready level and a falling-edge strobe, and the PLL reports a lock level.

Software changes the control fields through a small write port. A control write is accepted only after two key bytes have arrived on back-to-back write cycles. A switch waits for the target source to report ready. It then drops the old select on a falling-edge strobe of the old source and raises the new select on a falling-edge strobe of the target, so for at least one cycle no source is selected. After reset the block runs from the divided fast RC source and at once starts a switch to the configured boot source.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is high and directly after it: curSrc = 111, nextSrc = cfgBootSrc, swReq = 1, clkSel = 8'h80, clkLock = 0, pllLocked = 0, clkFail = 0.
- R2: Source codes are 000 fast RC, 001 fast RC with PLL, 010 primary, 011 primary with PLL, 100 secondary, 101 low-power RC, 110 reserved and 111 divided fast RC. When clkSel is non-zero, it is one-hot with bit curSrc set. A request that targets 110 is dropped: swReq clears and the select does not change.
- R3: A control write (busSel = 1) is accepted only if it directly follows, as the next write, key byte 0x46 and then key byte 0x57, both on busSel = 0 on consecutive cycles. An idle cycle between the keys, any other key write, or the one accepted control write closes the window.
- R4: Control byte layout: bits [2:0] next source, bit 3 request (1 sets swReq, 0 leaves it), bit 4 software lock.
- R5: A switch holds the old select until the target's srcReady is high. It then clears clkSel on an srcFall strobe of the old source and sets the target bit on an srcFall strobe of the target. clkSel never moves from one non-zero value directly to another.
- R6: curSrc changes only when a switch completes, and swReq clears at that point.
- R7: A request whose next source equals curSrc clears swReq and changes nothing else: no select change and no flag cleared.
- R8: When cfgLockEn = 1 and clkLock = 1, a request stays pending and no switch starts. When cfgLockEn = 0, the lock bit has no effect.
- R9: pllLocked sets from pllLockIn while no switch is running, clears when a valid switch starts, and reads 0 whenever curSrc is not 001 or 011.
- R10: clkFail sets on a clkFailIn pulse and clears when a valid switch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Write strobe, one cycle per write |
| busSel | input | 1 | 0 selects the key port, 1 selects the control register |
| busWdata | input | 8 | Write data |
| cfgBootSrc | input | 3 | Configured boot source code |
| cfgLockEn | input | 1 | Enables the software lock bit |
| srcReady | input | 8 | Per-code source ready level |
| srcFall | input | 8 | Per-code falling-edge strobe of each source |
| pllLockIn | input | 1 | PLL lock level |
| clkFailIn | input | 1 | Clock-failure pulse |
| clkSel | output | 8 | One-hot glitch-free mux select, indexed by code |
| curSrc | output | 3 | Current source code |
| nextSrc | output | 3 | Next source code |
| swReq | output | 1 | Switch request pending |
| clkLock | output | 1 | Software lock bit |
| pllLocked | output | 1 | PLL-locked flag |
| clkFail | output | 1 | Clock-fail flag |

## Verification
A table of switches runs through source pairs with the lock bit set and clear and with the lock enable on and off. This separates a lock that is ignored, a lock that blocks, and PLL versus non-PLL targets for the locked flag. Directed sequences then hold srcReady low and gate the falling-edge strobes one at a time, which shows that the select waits for the target and passes through an all-zero state. Redundant and reserved targets are checked against a real switch to show which flags each one clears. Broken key sequences are checked against an intact one to confirm the single-write window.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_SRC = 1 << CODE_W;

  typedef logic [CODE_W-1:0] srcCode_t;

  localparam srcCode_t SRC_FRC      = 3'b000;
  localparam srcCode_t SRC_FRC_PLL  = 3'b001;
  localparam srcCode_t SRC_PRI      = 3'b010;
  localparam srcCode_t SRC_PRI_PLL  = 3'b011;
  localparam srcCode_t SRC_SEC      = 3'b100;
  localparam srcCode_t SRC_LPRC     = 3'b101;
  localparam srcCode_t SRC_RSVD     = 3'b110;
  localparam srcCode_t SRC_FRC_DIV  = 3'b111;

  // control byte field positions
  localparam int F_NEXT_LSB = 0;
  localparam int F_REQ      = F_NEXT_LSB + CODE_W;
  localparam int F_LOCK     = F_REQ + 1;

  typedef enum logic [1:0] {SW_IDLE, SW_WAIT_RDY, SW_DROP_OLD, SW_PICK_NEW} swState_t;
  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} keyState_t;

  typedef struct packed {
    logic regWrite;
    logic startSw;
    logic dropOld;
    logic pickNew;
    logic dropReq;
    logic pllWatch;
  } swStrobe_t;

  function automatic logic usesPll(input srcCode_t c);
    return (c == SRC_FRC_PLL) || (c == SRC_PRI_PLL);
  endfunction
endpackage

// File: rtl/clksw_control.sv
`timescale 1ns/1ps
module clksw_control
  import clksw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h46,
  parameter logic [DATA_W-1:0] KEY_B = 8'h57
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cfgLockEn,
  input  logic [NUM_SRC-1:0] srcReady,
  input  logic [NUM_SRC-1:0] srcFall,
  input  srcCode_t          curSrc,
  input  srcCode_t          nextSrc,
  input  srcCode_t          tgtSrc,
  input  logic              swReq,
  input  logic              clkLock,
  output swStrobe_t         strb
);
  keyState_t keyState, keyNext;
  swState_t  swState, swNext;

  // unlock sequencer
  always_comb begin
    keyNext = keyState;
    if (busWr) begin
      if (!busSel) begin
        if (busWdata == KEY_A)
          keyNext = KEY_HALF;
        else if (busWdata == KEY_B && keyState == KEY_HALF)
          keyNext = KEY_OPEN;
        else
          keyNext = KEY_IDLE;
      end else begin
        keyNext = KEY_IDLE;
      end
    end else if (keyState == KEY_HALF) begin
      keyNext = KEY_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) keyState <= KEY_IDLE;
    else     keyState <= keyNext;
  end

  // switch sequencer
  always_comb begin
    strb          = '0;
    swNext        = swState;
    strb.regWrite = busWr && busSel && (keyState == KEY_OPEN);
    case (swState)
      SW_IDLE: begin
        strb.pllWatch = 1'b1;
        if (swReq) begin
          if (nextSrc == curSrc || nextSrc == SRC_RSVD) begin
            strb.dropReq = 1'b1;
          end else if (!(clkLock && cfgLockEn)) begin
            strb.startSw  = 1'b1;
            strb.pllWatch = 1'b0;
            swNext        = SW_WAIT_RDY;
          end
        end
      end
      SW_WAIT_RDY: if (srcReady[tgtSrc]) swNext = SW_DROP_OLD;
      SW_DROP_OLD: if (srcFall[curSrc]) begin
        strb.dropOld = 1'b1;
        swNext       = SW_PICK_NEW;
      end
      SW_PICK_NEW: if (srcFall[tgtSrc]) begin
        strb.pickNew = 1'b1;
        swNext       = SW_IDLE;
      end
      default: swNext = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) swState <= SW_IDLE;
    else     swState <= swNext;
  end
endmodule

// File: rtl/clksw_datapath.sv
`timescale 1ns/1ps
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  swStrobe_t          strb,
  input  logic [DATA_W-1:0]  wrData,
  input  srcCode_t           bootSrc,
  input  logic               pllLockIn,
  input  logic               clkFailIn,
  output srcCode_t           curSrc,
  output srcCode_t           nextSrc,
  output srcCode_t           tgtSrc,
  output logic               swReq,
  output logic               clkLock,
  output logic               pllLocked,
  output logic               clkFail,
  output logic [NUM_SRC-1:0] clkSel
);
  logic pllLockQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      curSrc  <= SRC_FRC_DIV;
      nextSrc <= bootSrc;
      tgtSrc  <= SRC_FRC_DIV;
      swReq   <= 1'b1;
      clkLock <= 1'b0;
    end else begin
      if (strb.startSw) tgtSrc <= nextSrc;
      if (strb.pickNew) curSrc <= tgtSrc;
      if (strb.regWrite && wrData[F_REQ])
        swReq <= 1'b1;
      else if (strb.dropReq || strb.pickNew)
        swReq <= 1'b0;
      if (strb.regWrite) begin
        nextSrc <= wrData[F_NEXT_LSB +: CODE_W];
        clkLock <= wrData[F_LOCK];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pllLockQ <= 1'b0;
      clkFail  <= 1'b0;
    end else begin
      if (strb.startSw)                   pllLockQ <= 1'b0;
      else if (strb.pllWatch && pllLockIn) pllLockQ <= 1'b1;
      if (clkFailIn)         clkFail <= 1'b1;
      else if (strb.startSw) clkFail <= 1'b0;
    end
  end

  assign pllLocked = pllLockQ & usesPll(curSrc);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        clkSel[i] <= (i == int'(SRC_FRC_DIV));
      else if (strb.dropOld)
        clkSel[i] <= 1'b0;
      else if (strb.pickNew && tgtSrc == srcCode_t'(i))
        clkSel[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h46,
  parameter logic [DATA_W-1:0] KEY_B = 8'h57
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWr,
  input  logic               busSel,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [CODE_W-1:0]  cfgBootSrc,
  input  logic               cfgLockEn,
  input  logic [NUM_SRC-1:0] srcReady,
  input  logic [NUM_SRC-1:0] srcFall,
  input  logic               pllLockIn,
  input  logic               clkFailIn,
  output logic [NUM_SRC-1:0] clkSel,
  output logic [CODE_W-1:0]  curSrc,
  output logic [CODE_W-1:0]  nextSrc,
  output logic               swReq,
  output logic               clkLock,
  output logic               pllLocked,
  output logic               clkFail
);
  swStrobe_t strb;
  srcCode_t  tgtSrc;

  clksw_control #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_control (
    .clk(clk), .rst(rst), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .cfgLockEn(cfgLockEn), .srcReady(srcReady), .srcFall(srcFall),
    .curSrc(curSrc), .nextSrc(nextSrc), .tgtSrc(tgtSrc), .swReq(swReq),
    .clkLock(clkLock), .strb(strb)
  );

  clksw_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rst(rst), .strb(strb), .wrData(busWdata), .bootSrc(cfgBootSrc),
    .pllLockIn(pllLockIn), .clkFailIn(clkFailIn), .curSrc(curSrc),
    .nextSrc(nextSrc), .tgtSrc(tgtSrc), .swReq(swReq), .clkLock(clkLock),
    .pllLocked(pllLocked), .clkFail(clkFail), .clkSel(clkSel)
  );
endmodule

// File: rtl/clksw_ctrl_chk.sv
`timescale 1ns/1ps
module clksw_ctrl_chk
  import clksw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] clkSel,
  input logic [CODE_W-1:0]  curSrc,
  input logic               pllLocked
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clkSel));

  // R5
  no_direct_handover_chk: assert property (@(posedge clk) disable iff (rst)
    (clkSel != '0 && $past(clkSel) != '0) |-> clkSel == $past(clkSel));

  // R6
  cur_moves_on_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (curSrc != $past(curSrc)) |-> ($past(clkSel) == '0 && clkSel[curSrc]));

  // R2
  sel_matches_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (clkSel != '0) |-> clkSel[curSrc]);

  // R2
  reserved_unused_chk: assert property (@(posedge clk) disable iff (rst)
    !clkSel[SRC_RSVD]);

  // R9
  pll_flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    pllLocked |-> usesPll(curSrc));
endmodule

bind clksw_ctrl clksw_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clkSel(clkSel), .curSrc(curSrc), .pllLocked(pllLocked)
);

// File: tb/clksw_ctrl_bench.sv
`timescale 1ns/1ps
module clksw_ctrl_bench;
  localparam logic [7:0] KEY_A = 8'h46;
  localparam logic [7:0] KEY_B = 8'h57;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busWr = 1'b0, busSel = 1'b0;
  logic [7:0] busWdata = '0;
  logic [2:0] cfgBootSrc = 3'b011;
  logic cfgLockEn = 1'b0;
  logic [7:0] srcReady = '0, srcFall = '0;
  logic pllLockIn = 1'b0, clkFailIn = 1'b0;
  logic [7:0] clkSel;
  logic [2:0] curSrc, nextSrc;
  logic swReq, clkLock, pllLocked, clkFail;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clksw_ctrl u_clksw_ctrl (
    .clk(clk), .rst(rst), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .cfgBootSrc(cfgBootSrc), .cfgLockEn(cfgLockEn), .srcReady(srcReady),
    .srcFall(srcFall), .pllLockIn(pllLockIn), .clkFailIn(clkFailIn),
    .clkSel(clkSel), .curSrc(curSrc), .nextSrc(nextSrc), .swReq(swReq),
    .clkLock(clkLock), .pllLocked(pllLocked), .clkFail(clkFail)
  );

  // {next[2:0], lock, lockEn, expCur[2:0], expReq, expPll}
  localparam int NVEC = 7;
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    {3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0},
    {3'b101, 1'b1, 1'b0, 3'b101, 1'b0, 1'b0},
    {3'b010, 1'b1, 1'b1, 3'b101, 1'b1, 1'b0},
    {3'b100, 1'b0, 1'b1, 3'b100, 1'b0, 1'b0},
    {3'b001, 1'b0, 1'b0, 3'b001, 1'b0, 1'b1},
    {3'b111, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0},
    {3'b011, 1'b0, 1'b1, 3'b011, 1'b0, 1'b1}
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busCycle(input logic sel, input logic [7:0] d);
    busWr = 1'b1; busSel = sel; busWdata = d;
    step();
    busWr = 1'b0;
  endtask

  function automatic logic [7:0] ctrlByte(input logic [2:0] nxt, input logic req, input logic lck);
    return {3'b000, lck, req, nxt};
  endfunction

  task automatic unlockWrite(input logic [7:0] d);
    busCycle(1'b0, KEY_A);
    busCycle(1'b0, KEY_B);
    busCycle(1'b1, d);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 curSrc", 32'(curSrc), 32'h7);
    check("R1 nextSrc", 32'(nextSrc), 32'h3);
    check("R1 swReq", 32'(swReq), 32'h1);
    check("R1 clkSel", 32'(clkSel), 32'h80);
    check("R1 flags", {clkLock, pllLocked, clkFail}, 32'h0);
    rst = 1'b0;
    step(4);
    // R5 waits for target ready
    check("R5 hold before ready", 32'(clkSel), 32'h80);
    srcReady[3] = 1'b1;
    step(3);
    check("R5 hold before old fall", 32'(clkSel), 32'h80);
    srcFall[7] = 1'b1; step(); srcFall[7] = 1'b0;
    check("R5 gap select", 32'(clkSel), 32'h0);
    check("R6 cur kept during gap", 32'(curSrc), 32'h7);
    step(2);
    srcFall[3] = 1'b1; step(); srcFall[3] = 1'b0;
    check("R5 new select", 32'(clkSel), 32'h08);
    check("R6 cur after boot", 32'(curSrc), 32'h3);
    check("R6 swReq cleared", 32'(swReq), 32'h0);
    pllLockIn = 1'b1;
    step(2);
    check("R9 pll flag set", 32'(pllLocked), 32'h1);

    // table of switches
    srcReady = '1; srcFall = '1;
    for (int v = 0; v < NVEC; v++) begin
      cfgLockEn = VEC[v][5];
      unlockWrite(ctrlByte(VEC[v][9:7], 1'b1, VEC[v][6]));
      step(8);
      check($sformatf("R8 vec%0d curSrc", v), 32'(curSrc), 32'(VEC[v][4:2]));
      check($sformatf("R2 vec%0d clkSel", v), 32'(clkSel), 32'(8'h01 << VEC[v][4:2]));
      check($sformatf("R6 vec%0d swReq", v), 32'(swReq), 32'(VEC[v][1]));
      check($sformatf("R9 vec%0d pllLocked", v), 32'(pllLocked), 32'(VEC[v][0]));
    end
    cfgLockEn = 1'b0;

    // R10 fail flag set
    clkFailIn = 1'b1; step(); clkFailIn = 1'b0;
    check("R10 fail set", 32'(clkFail), 32'h1);
    // R7 redundant request
    unlockWrite(ctrlByte(3'b011, 1'b1, 1'b0));
    step(4);
    check("R7 swReq cleared", 32'(swReq), 32'h0);
    check("R7 cur kept", 32'(curSrc), 32'h3);
    check("R7 sel kept", 32'(clkSel), 32'h08);
    check("R7 fail kept", 32'(clkFail), 32'h1);
    check("R7 pll kept", 32'(pllLocked), 32'h1);
    // R2 reserved target
    unlockWrite(ctrlByte(3'b110, 1'b1, 1'b0));
    step(4);
    check("R2 reserved swReq", 32'(swReq), 32'h0);
    check("R2 reserved cur", 32'(curSrc), 32'h3);
    check("R2 reserved sel", 32'(clkSel), 32'h08);
    // switch start clears flags, waits on ready
    srcReady = '0;
    unlockWrite(ctrlByte(3'b000, 1'b1, 1'b0));
    step(2);
    check("R9 pll cleared at start", 32'(pllLocked), 32'h0);
    check("R10 fail cleared at start", 32'(clkFail), 32'h0);
    check("R6 cur during switch", 32'(curSrc), 32'h3);
    step(4);
    check("R5 sel waits ready", 32'(clkSel), 32'h08);
    srcReady = '1;
    step(8);
    check("R6 cur after switch", 32'(curSrc), 32'h0);
    check("R5 sel after switch", 32'(clkSel), 32'h01);
    check("R9 pll zero non-pll src", 32'(pllLocked), 32'h0);

    // R3 unlock window
    busCycle(1'b1, ctrlByte(3'b101, 1'b1, 1'b0));
    step(4);
    check("R3 no keys next", 32'(nextSrc), 32'h0);
    check("R3 no keys req", 32'(swReq), 32'h0);
    busCycle(1'b0, KEY_A); step();
    busCycle(1'b0, KEY_B);
    busCycle(1'b1, ctrlByte(3'b101, 1'b1, 1'b0));
    step(4);
    check("R3 gap between keys", 32'(nextSrc), 32'h0);
    busCycle(1'b0, KEY_A);
    busCycle(1'b0, KEY_B);
    busCycle(1'b0, KEY_B);
    busCycle(1'b1, ctrlByte(3'b101, 1'b1, 1'b0));
    step(4);
    check("R3 extra key closes", 32'(nextSrc), 32'h0);
    unlockWrite(ctrlByte(3'b010, 1'b0, 1'b1));
    busCycle(1'b1, ctrlByte(3'b100, 1'b0, 1'b0));
    step(4);
    check("R3 single write next", 32'(nextSrc), 32'h2);
    check("R4 lock field", 32'(clkLock), 32'h1);
    check("R4 req zero no switch", 32'(swReq), 32'h0);
    check("R4 cur unchanged", 32'(curSrc), 32'h0);

    // R8 pending request released when lock enable drops
    cfgLockEn = 1'b1;
    unlockWrite(ctrlByte(3'b010, 1'b1, 1'b1));
    step(6);
    check("R8 blocked req", 32'(swReq), 32'h1);
    check("R8 blocked cur", 32'(curSrc), 32'h0);
    cfgLockEn = 1'b0;
    step(6);
    check("R8 released cur", 32'(curSrc), 32'h2);
    check("R8 released req", 32'(swReq), 32'h0);
    report();
  end
endmodule